// File: doc/BRIEF.md
# Serial start-bit wakeup controller

This block decides when a sleeping device may run again. Software first puts the device into a halt or idle state. While the device sleeps, the controller watches the serial receive pin. When an enabled transition of the chosen polarity arrives, such as the falling edge that starts a character, the controller releases the core. A pending flag records that a qualifying edge was seen. Software clears this flag by writing a one to it.

Leaving halt while a crystal supplies the clock needs extra time, because the oscillator was stopped and has to settle. In that case only, the run-enable output stays low for a fixed settling count. Leaving idle never waits, because the clock kept running. The pin passes through a synchroniser and an edge detector before any decision is made. The core uses `run_en` as its permission to execute.

Top module: `rxwake_ctrl`

## Requirements
- R1: After reset, `run_en` is 1, `wake_pend` is 0 and `asleep` is 0.
- R2: A `halt_req` pulse while running drives `run_en` to 0 at the next rising clock edge. When `halt_req` and `idle_req` arrive together, halt is entered, so a later wake with `xtal_sel`=1 includes the settling delay.
- R3: An `idle_req` pulse while running drives `run_en` to 0 at the next rising clock edge, and `asleep` reads 1.
- R4: With `wake_en`=1 and `edge_sel`=1, a high-to-low change on `rx_pin` ends idle, or halt with `xtal_sel`=0. `run_en` rises on the third rising clock edge counted from the first edge that samples the new pin level.
- R5: With `edge_sel`=0, a low-to-high change on `rx_pin` is the trigger, with the same timing as R4. A high-to-low change does not end sleep and does not set `wake_pend`.
- R6: With `edge_sel`=1, a low-to-high change on `rx_pin` does not end sleep and does not set `wake_pend`.
- R7: With `wake_en`=0, no change on `rx_pin` ends halt or idle, and `wake_pend` stays 0.
- R8: A wake from halt with `xtal_sel`=1 raises `run_en` exactly SETTLE_CYCLES (default 256) clock edges later than the R4 timing. `run_en` stays 0 throughout that interval.
- R9: A wake from idle with `xtal_sel`=1 follows the R4 timing, with no settling delay.
- R10: `wake_pend` becomes 1 on a qualifying edge and holds until a cycle with `pend_clr`=1, after which it reads 0 at the next rising edge. If a qualifying edge arrives in the same cycle as the clear, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_pin | input | 1 | Asynchronous serial receive pin |
| wake_en | input | 1 | Allows pin edges to end sleep |
| edge_sel | input | 1 | 1 = falling edge triggers, 0 = rising edge |
| halt_req | input | 1 | Request to enter halt (single-cycle pulse) |
| idle_req | input | 1 | Request to enter idle (single-cycle pulse) |
| xtal_sel | input | 1 | 1 when a crystal oscillator is the clock source |
| pend_clr | input | 1 | Write-one-to-clear for the pending flag |
| run_en | output | 1 | Core may execute |
| wake_pend | output | 1 | Qualifying edge has been seen |
| asleep | output | 1 | Halt or idle state is active |

## Verification
Wake cycles are tried over four combinations:
- idle and halt, each with and without a crystal;
- both falling-edge and rising-edge triggers.

Together these separate the settling path from the immediate path and show that the polarity select works. Edges that should have no effect are also applied, and the bench checks that `run_en` and `wake_pend` do not move:
- a disabled pin;
- a rising edge under falling select;
- a falling edge under rising select.

Simultaneous halt and idle requests followed by a crystal wake show which request has priority. Exact wake latencies are compared cycle by cycle, so a missing or extra synchroniser stage is caught, and so is an off-by-one in the settling count.

// File: rtl/rxwake_pkg.sv
// Package: shared types for the start-bit wakeup controller.
// Assumes: nothing beyond the encoding below, which only this block decodes.
package rxwake_pkg;

    // Power states of the controller.
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HALT   = 2'd1,
        ST_IDLE   = 2'd2,
        ST_SETTLE = 2'd3
    } wake_state_t;

endpackage

// File: rtl/rxwake_sync.sv
// Module: rxwake_sync
// Brings the asynchronous pin into the clock domain through STAGES flops,
// then keeps one more flop to detect rising and falling edges.
// Assumes: the pin idles at RESET_LEVEL, so reset produces no false edge.
module rxwake_sync #(
    parameter int   STAGES      = 2,
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise,
    output logic fall
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain;
    logic               cur_lvl;
    logic               prev_lvl;

    // Shift the pin through the synchroniser and the history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {CHAIN_W{RESET_LEVEL}};
        end else begin
            chain <= {chain[CHAIN_W-2:0], pin_async};
        end
    end

    // Compare the synchronised level with the level one cycle older.
    always_comb begin
        cur_lvl  = chain[STAGES-1];
        prev_lvl = chain[STAGES];
        rise     = cur_lvl & ~prev_lvl;
        fall     = ~cur_lvl & prev_lvl;
    end

endmodule

// File: rtl/rxwake_qual.sv
// Module: rxwake_qual
// Qualifies synchronised edges with the enable and polarity select, and
// holds the sticky pending flag that software clears by writing a one.
// Assumes: rise and fall are single-cycle pulses from rxwake_sync.
module rxwake_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic fall,
    input  logic wake_en,
    input  logic edge_sel,
    input  logic pend_clr,
    output logic trig,
    output logic pend
);

    // Choose the polarity, then gate it with the per-pin enable.
    always_comb begin
        trig = wake_en & (edge_sel ? fall : rise);
    end

    // Pending flag: a new edge takes priority over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (trig) begin
            pend <= 1'b1;
        end else if (pend_clr) begin
            pend <= 1'b0;
        end
    end

endmodule

// File: rtl/rxwake_settle.sv
// Module: rxwake_settle
// Counts the oscillator settling interval while active is high.
// done is raised in the last active cycle, so the caller leaves the
// settle state exactly CYCLES edges after entering it.
// Assumes: active falls after done and stays low between intervals.
module rxwake_settle #(
    parameter int CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    // Count cycles spent settling, and restart from zero whenever idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!active) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Flag the final cycle of the interval.
    always_comb begin
        done = active && (cnt == CW'(CYCLES - 1));
    end

endmodule

// File: rtl/rxwake_fsm.sv
// Module: rxwake_fsm
// Power-state sequencer: run, halt, idle and post-halt settling.
// A halt request wins over an idle request in the same cycle. Requests
// are ignored unless the controller is running.
// Assumes: trig is already qualified, and settle_done comes from the counter.
module rxwake_fsm
    import rxwake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_req,
    input  logic idle_req,
    input  logic trig,
    input  logic xtal_sel,
    input  logic settle_done,
    output logic run_en,
    output logic settling,
    output logic asleep
);

    wake_state_t state;
    wake_state_t state_nx;

    // Next-state decision for each power state.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (halt_req) begin
                    state_nx = ST_HALT;
                end else if (idle_req) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_HALT: begin
                if (trig) begin
                    state_nx = xtal_sel ? ST_SETTLE : ST_RUN;
                end
            end
            ST_IDLE: begin
                if (trig) begin
                    state_nx = ST_RUN;
                end
            end
            ST_SETTLE: begin
                if (settle_done) begin
                    state_nx = ST_RUN;
                end
            end
            default: state_nx = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_nx;
        end
    end

    // Decode the state into the outputs.
    always_comb begin
        run_en   = (state == ST_RUN);
        settling = (state == ST_SETTLE);
        asleep   = (state == ST_HALT) || (state == ST_IDLE);
    end

endmodule

// File: rtl/rxwake_ctrl.sv
// Module: rxwake_ctrl (top)
// Wakes the device from halt or idle on an enabled edge of the receive pin.
// After a halt with a crystal clock, it holds run_en low for SETTLE_CYCLES.
// Assumes: halt_req and idle_req are pulses from the core.
// Assumes: rx_pin is asynchronous and idles high.
module rxwake_ctrl #(
    parameter int SYNC_STAGES   = 2,
    parameter int SETTLE_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_pin,
    input  logic wake_en,
    input  logic edge_sel,
    input  logic halt_req,
    input  logic idle_req,
    input  logic xtal_sel,
    input  logic pend_clr,
    output logic run_en,
    output logic wake_pend,
    output logic asleep
);

    logic rise;
    logic fall;
    logic trig;
    logic settling;
    logic settle_done;

    rxwake_sync #(
        .STAGES      (SYNC_STAGES),
        .RESET_LEVEL (1'b1)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (rx_pin),
        .rise      (rise),
        .fall      (fall)
    );

    rxwake_qual u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .fall     (fall),
        .wake_en  (wake_en),
        .edge_sel (edge_sel),
        .pend_clr (pend_clr),
        .trig     (trig),
        .pend     (wake_pend)
    );

    rxwake_settle #(
        .CYCLES (SETTLE_CYCLES)
    ) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (settling),
        .done   (settle_done)
    );

    rxwake_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_req    (halt_req),
        .idle_req    (idle_req),
        .trig        (trig),
        .xtal_sel    (xtal_sel),
        .settle_done (settle_done),
        .run_en      (run_en),
        .settling    (settling),
        .asleep      (asleep)
    );

endmodule

// File: rtl/rxwake_checker.sv
// Module: rxwake_checker
// Temporal checks on the wakeup controller, attached with bind.
// Assumes: it sees the top ports plus the internal settling indicator.
module rxwake_checker #(
    parameter int SETTLE_CYCLES = 256
) (
    input logic clk,
    input logic rst_n,
    input logic wake_en,
    input logic halt_req,
    input logic idle_req,
    input logic pend_clr,
    input logic run_en,
    input logic wake_pend,
    input logic settling
);

    logic [31:0] win_cnt;

    // Length of the current unbroken settling window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
        end else if (settling) begin
            win_cnt <= win_cnt + 1;
        end else begin
            win_cnt <= '0;
        end
    end

    // R2 and R3: a sleep request while running stops execution at the next edge.
    assert_sleep_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && (halt_req || idle_req)) |=> !run_en);

    // R10: with no possible trigger, a clear empties the flag.
    assert_pend_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr && !wake_en) |=> !wake_pend);

    // R7: a disabled pin never ends sleep.
    assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !settling && !wake_en) |=> !run_en);

    // R8: a settling window lasts exactly SETTLE_CYCLES before run resumes.
    assert_settle_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(run_en) && $past(settling)) |-> (win_cnt == SETTLE_CYCLES));

endmodule

bind rxwake_ctrl rxwake_checker #(
    .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wake_en   (wake_en),
    .halt_req  (halt_req),
    .idle_req  (idle_req),
    .pend_clr  (pend_clr),
    .run_en    (run_en),
    .wake_pend (wake_pend),
    .settling  (settling)
);

// File: tb/rxwake_ctrl_bench.sv
// Bench for rxwake_ctrl. The driver tasks push the expected wake cycle of
// each scenario into a queue. A monitor pops an item at every rising edge
// of run_en and compares the cycles.
module rxwake_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 256;
    localparam int WAKE_LAT   = 3;

    typedef struct {
        int    exp_cyc;
        string tag;
    } wake_item_t;

    logic clk = 1'b0;
    logic rst_n;
    logic rx_pin, wake_en, edge_sel, halt_req, idle_req, xtal_sel, pend_clr;
    logic run_en, wake_pend, asleep;

    int         cyc = 0;
    int         n_checks = 0;
    int         n_bad = 0;
    bit         prev_run = 1'b1;
    wake_item_t exp_q[$];

    rxwake_ctrl #(
        .SYNC_STAGES   (2),
        .SETTLE_CYCLES (SETTLE)
    ) u_rxwake_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_pin    (rx_pin),
        .wake_en   (wake_en),
        .edge_sel  (edge_sel),
        .halt_req  (halt_req),
        .idle_req  (idle_req),
        .xtal_sel  (xtal_sel),
        .pend_clr  (pend_clr),
        .run_en    (run_en),
        .wake_pend (wake_pend),
        .asleep    (asleep)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: every wake must match the oldest expected item.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && run_en && !prev_run) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected wake", cyc, -1);
            end else begin
                wake_item_t it;
                it = exp_q.pop_front();
                check(cyc == it.exp_cyc, it.tag, cyc, it.exp_cyc);
            end
        end
        prev_run = run_en;
    end

    task automatic wait_drain(input string tag);
        for (int i = 0; i < 400 && exp_q.size() > 0; i++) @(negedge clk);
        if (exp_q.size() > 0) begin
            check(1'b0, tag, exp_q.size(), 0);
            exp_q.delete();
        end
    endtask

    // Driver: sleep, apply a qualifying edge, and expect the wake time.
    task automatic wake_case(input bit do_halt, input bit do_idle, input bit xtal,
                             input bit rise_trig, input string tag);
        wake_item_t it;
        @(negedge clk);
        wake_en  = 1'b1;
        edge_sel = !rise_trig;
        xtal_sel = xtal;
        rx_pin   = rise_trig ? 1'b0 : 1'b1;
        repeat (5) @(negedge clk);
        pend_clr = 1'b1;
        @(negedge clk);
        pend_clr = 1'b0;
        halt_req = do_halt;
        idle_req = do_idle;
        @(negedge clk);
        halt_req = 1'b0;
        idle_req = 1'b0;
        check(run_en == 1'b0, {tag, " R2/R3 sleep entry"}, run_en, 0);
        check(asleep == 1'b1, {tag, " R3 asleep"}, asleep, 1);
        repeat (3) @(negedge clk);
        check(wake_pend == 1'b0, {tag, " R10 nothing pending"}, wake_pend, 0);
        rx_pin     = rise_trig ? 1'b1 : 1'b0;
        it.exp_cyc = cyc + WAKE_LAT + ((do_halt && xtal) ? SETTLE : 0);
        it.tag     = {tag, " wake cycle"};
        exp_q.push_back(it);
        wait_drain({tag, " wake timeout"});
        check(wake_pend == 1'b1, {tag, " R10 pending set"}, wake_pend, 1);
        pend_clr = 1'b1;
        @(negedge clk);
        pend_clr = 1'b0;
        check(wake_pend == 1'b0, {tag, " R10 pending cleared"}, wake_pend, 0);
    endtask

    // Driver: an edge that must be ignored, then a legal edge to recover.
    task automatic no_wake_case(input bit en, input bit sel, input bit pin_from,
                                input string tag);
        wake_item_t it;
        @(negedge clk);
        wake_en  = en;
        edge_sel = sel;
        xtal_sel = 1'b0;
        rx_pin   = pin_from;
        repeat (5) @(negedge clk);
        pend_clr = 1'b1;
        @(negedge clk);
        pend_clr = 1'b0;
        idle_req = 1'b1;
        @(negedge clk);
        idle_req = 1'b0;
        rx_pin   = !pin_from;
        repeat (12) @(negedge clk);
        check(run_en == 1'b0, {tag, " still asleep"}, run_en, 0);
        check(wake_pend == 1'b0, {tag, " no pending"}, wake_pend, 0);
        wake_en  = 1'b1;
        edge_sel = !pin_from;
        repeat (4) @(negedge clk);
        rx_pin     = pin_from;
        it.exp_cyc = cyc + WAKE_LAT;
        it.tag     = {tag, " recovery wake"};
        exp_q.push_back(it);
        wait_drain({tag, " recovery timeout"});
    endtask

    task automatic finish_run();
        check(exp_q.size() == 0, "scoreboard empty", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        rst_n    = 1'b0;
        rx_pin   = 1'b1;
        wake_en  = 1'b1;
        edge_sel = 1'b1;
        halt_req = 1'b0;
        idle_req = 1'b0;
        xtal_sel = 1'b0;
        pend_clr = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(run_en == 1'b1, "R1 run_en after reset", run_en, 1);
        check(wake_pend == 1'b0, "R1 wake_pend after reset", wake_pend, 0);
        check(asleep == 1'b0, "R1 asleep after reset", asleep, 0);

        wake_case(1'b0, 1'b1, 1'b0, 1'b0, "R3 R4 idle falling");
        wake_case(1'b1, 1'b0, 1'b0, 1'b0, "R2 R4 halt no crystal");
        wake_case(1'b1, 1'b0, 1'b1, 1'b0, "R8 halt crystal");
        wake_case(1'b0, 1'b1, 1'b1, 1'b0, "R9 idle crystal");
        wake_case(1'b0, 1'b1, 1'b0, 1'b1, "R5 idle rising");
        wake_case(1'b1, 1'b1, 1'b1, 1'b0, "R2 halt over idle");

        no_wake_case(1'b0, 1'b1, 1'b1, "R7 disabled");
        no_wake_case(1'b1, 1'b1, 1'b0, "R6 rising under falling select");
        no_wake_case(1'b1, 1'b0, 1'b1, "R5 falling under rising select");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule